// File: doc/BRIEF.md
# Day-Hour-Minute-Second Counter with Alarm

This block is a register-mapped elapsed-time counter. It keeps seconds, minutes, hours and a free-running day count. An external one-second pulse advances the count while the block is switched on. The time value equals ((day*24 + hour)*60 + minute)*60 + second. Seconds and minutes roll over at 60, and hours roll over at 24 into the day count. The day count is a plain binary counter and is not a calendar.

A second set of registers holds an alarm time made of the same four fields. Alarm matching is tested only on a cycle in which the time steps forward. When a step lands exactly on the alarm time, the block emits a one-cycle event and sets a sticky status flag. Software clears the flag by writing a 1 to it. A 16-bit register bus gives access to every register: an address, a write strobe, write data and combinational read data.

Top module: `dhms_rtc`

## Requirements
- R1: After reset, every register reads as zero and `alarm_evt` is low.
- R2: Offset 0x00 holds the running hour in bits [15:8] and the minute in bits [7:0]. Offset 0x04 holds the seconds in bits [5:0]. Offset 0x20 holds the day count. The alarm copies sit at 0x08 (hour/minute, same layout), 0x0C (seconds) and 0x24 (day). Each register reads back what was last written to it. Only 5 hour bits and 6 minute and second bits are stored, and the unused bits read as zero.
- R3: A tick accepted while the block is on raises the seconds by one. Seconds at 59 go to 0 and carry into the minutes. Minutes at 59 go to 0 and carry into the hours. Hours at 23 go to 0 and carry into the day count.
- R4: The day count is `DAY_W` bits wide (16 by default, 9 for the reduced variant). It wraps from all-ones to zero, and the read bits above `DAY_W` are zero.
- R5: Bit 7 at offset 0x10 is the run enable. It reads back as written, and the other bits of that register read as zero. While it is clear, ticks change no time field.
- R6: A tick that arrives in the same cycle as a write to 0x00, 0x04 or 0x20 is dropped, and the written value is what reads back. A write to an alarm or control register does not block a tick.
- R7: When an accepted tick moves the time to a value whose day, hour, minute and second all equal the alarm registers, `alarm_evt` is high for exactly the following cycle. In the same cycle, bit 2 at offset 0x14 reads as 1.
- R8: Matching is tested only on accepted ticks. Writing a time equal to the alarm produces no event. Ticks while the block is off produce no event, and a matching time that stays unchanged produces no further event.
- R9: Status bit 2 stays set until a write to 0x14 with bit 2 set clears it. A write with bit 2 clear has no effect. A new match in the same cycle as the clearing write leaves the bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 6 | Byte offset of the register |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| tick_1s | input | 1 | One-second pulse, one cycle wide |
| alarm_evt | output | 1 | One-cycle alarm event |

## Verification
Several functions can fall in the same cycle. A tick can arrive together with a software write to a time field. A tick can also arrive together with a write to the alarm, control or status register, including a status clear that meets a fresh match. The bench provokes these cases with directed cycles that raise `tick_1s` and `bus_we` together. It also runs a seeded random mix that overlaps ticks with writes to every register. Each case is judged against a bench model: a time write drops the tick, any other write lets the step through, and a set of the status flag wins over its clear.

// File: rtl/dhms_pkg.sv
package dhms_pkg;
  localparam int SEC_W = 6;
  localparam int MIN_W = 6;
  localparam int HR_W  = 5;
  localparam int BUS_W = 16;
  localparam int ADR_W = 6;

  localparam logic [ADR_W-1:0] OFS_HM    = 6'h00;
  localparam logic [ADR_W-1:0] OFS_SEC   = 6'h04;
  localparam logic [ADR_W-1:0] OFS_AHM   = 6'h08;
  localparam logic [ADR_W-1:0] OFS_ASEC  = 6'h0C;
  localparam logic [ADR_W-1:0] OFS_CTRL  = 6'h10;
  localparam logic [ADR_W-1:0] OFS_STAT  = 6'h14;
  localparam logic [ADR_W-1:0] OFS_DAY   = 6'h20;
  localparam logic [ADR_W-1:0] OFS_ADAY  = 6'h24;

  localparam int RUN_BIT = 7;
  localparam int HIT_BIT = 2;

  // next value of a modulo field: at or above its last value it returns to zero
  function automatic int unsigned field_bump(input int unsigned v, input int unsigned last);
    return (v >= last) ? 0 : v + 1;
  endfunction

  function automatic logic field_ends(input int unsigned v, input int unsigned last);
    return v >= last;
  endfunction
endpackage

// File: rtl/dhms_digit.sv
module dhms_digit
  import dhms_pkg::*;
#(
  parameter int W    = 6,
  parameter int LAST = 59
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  output logic [W-1:0] val,
  output logic [W-1:0] nxt,
  output logic         carry
);
  always_comb begin
    carry = inc && field_ends(int'(val), LAST);
    nxt   = inc ? W'(field_bump(int'(val), LAST)) : val;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)  val <= '0;
    else if (ld) val <= ld_val;
    else         val <= nxt;
  end

  // R3: a field at its last value returns to zero on an increment
  assert_field_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !ld && val == W'(LAST)) |=> (val == '0));

  // R5: without increment or load, the field holds
  assert_field_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc && !ld) |=> $stable(val));

  // R6: a load always lands
  assert_load_lands_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> (val == $past(ld_val)));
endmodule

// File: rtl/dhms_match.sv
module dhms_match
  import dhms_pkg::*;
#(
  parameter int DAY_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic [SEC_W-1:0] t_sec,
  input  logic [MIN_W-1:0] t_min,
  input  logic [HR_W-1:0]  t_hr,
  input  logic [DAY_W-1:0] t_day,
  input  logic [SEC_W-1:0] a_sec,
  input  logic [MIN_W-1:0] a_min,
  input  logic [HR_W-1:0]  a_hr,
  input  logic [DAY_W-1:0] a_day,
  output logic             hit,
  output logic             evt
);
  logic same;

  always_comb begin
    same = (t_sec == a_sec) && (t_min == a_min) && (t_hr == a_hr) && (t_day == a_day);
    hit  = step && same;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) evt <= 1'b0;
    else        evt <= hit;
  end

  // R8: an event only follows an accepted step
  assert_evt_after_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    evt |-> $past(step));

  // R7: the event lasts a single cycle
  assert_evt_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> !evt);
endmodule

// File: rtl/dhms_rtc.sv
module dhms_rtc
  import dhms_pkg::*;
#(
  parameter int DAY_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ADR_W-1:0] bus_addr,
  input  logic             bus_we,
  input  logic [BUS_W-1:0] bus_wdata,
  output logic [BUS_W-1:0] bus_rdata,
  input  logic             tick_1s,
  output logic             alarm_evt
);
  localparam int DAY_LAST = (1 << DAY_W) - 1;

  logic             run_en;
  logic             hit_flag;
  logic [SEC_W-1:0] al_sec;
  logic [MIN_W-1:0] al_min;
  logic [HR_W-1:0]  al_hr;
  logic [DAY_W-1:0] al_day;

  logic ld_hm, ld_sec, ld_day, ld_ahm, ld_asec, ld_aday, ld_ctrl, ld_stat;
  logic step, hit, clr_hit;

  logic [SEC_W-1:0] cur_sec, nx_sec;
  logic [MIN_W-1:0] cur_min, nx_min;
  logic [HR_W-1:0]  cur_hr,  nx_hr;
  logic [DAY_W-1:0] cur_day, nx_day;
  logic c_sec, c_min, c_hr, c_day;

  always_comb begin
    ld_hm   = bus_we && (bus_addr == OFS_HM);
    ld_sec  = bus_we && (bus_addr == OFS_SEC);
    ld_day  = bus_we && (bus_addr == OFS_DAY);
    ld_ahm  = bus_we && (bus_addr == OFS_AHM);
    ld_asec = bus_we && (bus_addr == OFS_ASEC);
    ld_aday = bus_we && (bus_addr == OFS_ADAY);
    ld_ctrl = bus_we && (bus_addr == OFS_CTRL);
    ld_stat = bus_we && (bus_addr == OFS_STAT);
    clr_hit = ld_stat && bus_wdata[HIT_BIT];
    step    = tick_1s && run_en && !(ld_hm || ld_sec || ld_day);
  end

  dhms_digit #(.W(SEC_W), .LAST(59)) u_sec (
    .clk(clk), .rst_n(rst_n), .inc(step), .ld(ld_sec),
    .ld_val(bus_wdata[SEC_W-1:0]), .val(cur_sec), .nxt(nx_sec), .carry(c_sec));

  dhms_digit #(.W(MIN_W), .LAST(59)) u_min (
    .clk(clk), .rst_n(rst_n), .inc(c_sec), .ld(ld_hm),
    .ld_val(bus_wdata[MIN_W-1:0]), .val(cur_min), .nxt(nx_min), .carry(c_min));

  dhms_digit #(.W(HR_W), .LAST(23)) u_hr (
    .clk(clk), .rst_n(rst_n), .inc(c_min), .ld(ld_hm),
    .ld_val(bus_wdata[8+HR_W-1:8]), .val(cur_hr), .nxt(nx_hr), .carry(c_hr));

  dhms_digit #(.W(DAY_W), .LAST(DAY_LAST)) u_day (
    .clk(clk), .rst_n(rst_n), .inc(c_hr), .ld(ld_day),
    .ld_val(bus_wdata[DAY_W-1:0]), .val(cur_day), .nxt(nx_day), .carry(c_day));

  dhms_match #(.DAY_W(DAY_W)) u_match (
    .clk(clk), .rst_n(rst_n), .step(step),
    .t_sec(nx_sec), .t_min(nx_min), .t_hr(nx_hr), .t_day(nx_day),
    .a_sec(al_sec), .a_min(al_min), .a_hr(al_hr), .a_day(al_day),
    .hit(hit), .evt(alarm_evt));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_en   <= 1'b0;
      hit_flag <= 1'b0;
      al_sec   <= '0;
      al_min   <= '0;
      al_hr    <= '0;
      al_day   <= '0;
    end else begin
      if (ld_ctrl) run_en <= bus_wdata[RUN_BIT];
      if (ld_ahm) begin
        al_hr  <= bus_wdata[8+HR_W-1:8];
        al_min <= bus_wdata[MIN_W-1:0];
      end
      if (ld_asec) al_sec <= bus_wdata[SEC_W-1:0];
      if (ld_aday) al_day <= bus_wdata[DAY_W-1:0];
      if (hit)          hit_flag <= 1'b1;
      else if (clr_hit) hit_flag <= 1'b0;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      OFS_HM:   begin bus_rdata[8+HR_W-1:8] = cur_hr; bus_rdata[MIN_W-1:0] = cur_min; end
      OFS_SEC:  bus_rdata[SEC_W-1:0] = cur_sec;
      OFS_AHM:  begin bus_rdata[8+HR_W-1:8] = al_hr; bus_rdata[MIN_W-1:0] = al_min; end
      OFS_ASEC: bus_rdata[SEC_W-1:0] = al_sec;
      OFS_CTRL: bus_rdata[RUN_BIT] = run_en;
      OFS_STAT: bus_rdata[HIT_BIT] = hit_flag;
      OFS_DAY:  bus_rdata[DAY_W-1:0] = cur_day;
      OFS_ADAY: bus_rdata[DAY_W-1:0] = al_day;
      default:  bus_rdata = '0;
    endcase
  end

  // R7: an event always comes with the status flag set
  assert_evt_sets_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_evt |-> hit_flag);

  // R5: the enable bit reads back as written
  assert_enable_readback_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ld_ctrl |=> (run_en == $past(bus_wdata[RUN_BIT])));

  // R6: a time write holds off the step on the seconds field
  assert_write_over_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_sec && tick_1s) |=> (cur_sec == $past(bus_wdata[SEC_W-1:0])));

  // R9: the flag only drops through a clearing write
  assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_flag && !clr_hit) |=> hit_flag);
endmodule

// File: tb/dhms_rtc_tb.sv
module dhms_rtc_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        tick_1s = 1'b0;
  logic        alarm_evt;

  int n_chk = 0;
  int n_err = 0;

  // bench model
  int m_sec, m_min, m_hr, m_day, a_sec, a_min, a_hr, a_day;
  bit m_en, m_stat;

  always #2 clk = ~clk;

  dhms_rtc u_dut (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_1s(tick_1s), .alarm_evt(alarm_evt));

  task automatic chk(input string tag, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_err++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  function automatic bit is_time_ofs(input logic [5:0] a);
    return a == 6'h00 || a == 6'h04 || a == 6'h20;
  endfunction

  function automatic int expect_read(input logic [5:0] a);
    case (a)
      6'h00: return (m_hr << 8) | m_min;
      6'h04: return m_sec;
      6'h08: return (a_hr << 8) | a_min;
      6'h0C: return a_sec;
      6'h10: return m_en ? 32'h80 : 0;
      6'h14: return m_stat ? 32'h4 : 0;
      6'h20: return m_day;
      6'h24: return a_day;
      default: return 0;
    endcase
  endfunction

  // elapsed seconds, restated as a single number
  function automatic longint total(input int d, input int h, input int mi, input int s);
    return ((longint'(d) * 24 + h) * 60 + mi) * 60 + s;
  endfunction

  function automatic void model_advance();
    longint t = total(m_day, m_hr, m_min, m_sec) + 1;
    longint per_day = 86400;
    longint tod = t % per_day;
    m_day = int'((t / per_day) % 65536);
    m_hr  = int'(tod / 3600);
    m_min = int'((tod % 3600) / 60);
    m_sec = int'(tod % 60);
  endfunction

  // one bus cycle, optionally with a tick; returns the expected event
  task automatic cyc(input bit tk, input bit we, input logic [5:0] a, input logic [15:0] d,
                     input string tag);
    bit stp, ehit;
    @(negedge clk);
    tick_1s = tk; bus_we = we; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    stp  = tk && m_en && !(we && is_time_ofs(a));
    if (stp) model_advance();
    ehit = stp && m_sec == a_sec && m_min == a_min && m_hr == a_hr && m_day == a_day;
    if (we) begin
      case (a)
        6'h00: begin m_hr = d[12:8]; m_min = d[5:0]; end
        6'h04: m_sec = d[5:0];
        6'h20: m_day = d;
        6'h08: begin a_hr = d[12:8]; a_min = d[5:0]; end
        6'h0C: a_sec = d[5:0];
        6'h24: a_day = d;
        6'h10: m_en = d[7];
        default: ;
      endcase
    end
    if (ehit) m_stat = 1'b1;
    else if (we && a == 6'h14 && d[2]) m_stat = 1'b0;
    @(negedge clk);
    chk({tag, " evt"}, int'(alarm_evt), int'(ehit));
    tick_1s = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd_chk(input logic [5:0] a, input string tag);
    @(negedge clk);
    bus_we = 1'b0; tick_1s = 1'b0; bus_addr = a;
    #1;
    chk(tag, int'(bus_rdata), expect_read(a));
  endtask

  task automatic chk_time(input string tag);
    rd_chk(6'h00, {tag, " hm"});
    rd_chk(6'h04, {tag, " sec"});
    rd_chk(6'h20, {tag, " day"});
  endtask

  task automatic set_time(input int d, input int h, input int mi, input int s);
    cyc(0, 1, 6'h20, 16'(d), "R2 set day");
    cyc(0, 1, 6'h00, 16'((h << 8) | mi), "R2 set hm");
    cyc(0, 1, 6'h04, 16'(s), "R2 set sec");
  endtask

  task automatic set_alarm(input int d, input int h, input int mi, input int s);
    cyc(0, 1, 6'h24, 16'(d), "R2 set aday");
    cyc(0, 1, 6'h08, 16'((h << 8) | mi), "R2 set ahm");
    cyc(0, 1, 6'h0C, 16'(s), "R2 set asec");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    int unsigned seed = 32'h1234;
    int r;
    {m_sec, m_min, m_hr, m_day, a_sec, a_min, a_hr, a_day} = '0;
    m_en = 0; m_stat = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset values
    for (int i = 0; i < 10; i++) rd_chk(6'(i * 4), "R1 reset read");
    chk("R1 evt after reset", int'(alarm_evt), 0);

    // R2 layout and readback
    set_time(16'h0123, 10, 43, 17);
    rd_chk(6'h00, "R2 hm layout");
    chk("R2 hm raw", int'(bus_rdata), 16'h0A2B);
    set_alarm(16'h0042, 5, 7, 33);
    rd_chk(6'h08, "R2 alarm hm");
    rd_chk(6'h0C, "R2 alarm sec");
    rd_chk(6'h24, "R2 alarm day");

    // R5 off: ticks ignored; control readback
    cyc(1, 0, 0, 0, "R5 tick while off");
    chk_time("R5 hold while off");
    cyc(0, 1, 6'h10, 16'hFFFF, "R5 enable");
    rd_chk(6'h10, "R5 ctrl readback");
    chk("R5 ctrl raw", int'(bus_rdata), 16'h0080);

    // R3 plain step and carries
    set_time(3, 4, 5, 58);
    cyc(1, 0, 0, 0, "R3 step");
    chk_time("R3 no carry");
    cyc(1, 0, 0, 0, "R3 step");
    chk_time("R3 sec carry");
    set_time(3, 23, 59, 59);
    cyc(1, 0, 0, 0, "R3 day carry");
    chk_time("R3 day carry");
    chk("R3 day is 4", m_day, 4);

    // R4 day wrap
    set_time(16'hFFFF, 23, 59, 59);
    cyc(1, 0, 0, 0, "R4 wrap");
    chk_time("R4 day wrap");

    // R6 tick concurrent with writes
    set_time(7, 1, 2, 3);
    cyc(1, 1, 6'h04, 16'd30, "R6 tick+sec write");
    chk_time("R6 sec write wins");
    cyc(1, 1, 6'h00, 16'h0509, "R6 tick+hm write");
    chk_time("R6 hm write wins");
    cyc(1, 1, 6'h24, 16'd900, "R6 tick+alarm write");
    chk_time("R6 alarm write passes tick");

    // R7 alarm fires on the step landing on the match
    set_alarm(20, 0, 0, 5);
    set_time(20, 0, 0, 4);
    cyc(1, 0, 0, 0, "R7 match");
    rd_chk(6'h14, "R7 status set");
    cyc(0, 0, 0, 0, "R7 one-cycle evt");

    // R9 sticky flag and clearing
    cyc(0, 1, 6'h14, 16'h0000, "R9 write zero");
    rd_chk(6'h14, "R9 zero has no effect");
    cyc(0, 1, 6'h14, 16'h0004, "R9 clear");
    rd_chk(6'h14, "R9 cleared");

    // R8 no event without a step
    set_time(20, 0, 0, 5);
    rd_chk(6'h14, "R8 write equal no flag");
    cyc(0, 1, 6'h10, 16'h0000, "R8 off");
    set_time(20, 0, 0, 4);
    cyc(1, 0, 0, 0, "R8 tick while off no evt");
    cyc(0, 1, 6'h10, 16'h0080, "R8 on");
    cyc(1, 1, 6'h04, 16'd5, "R8 tick+write equal no evt");
    rd_chk(6'h14, "R8 flag still clear");

    // R9 set wins over clear in same cycle
    set_time(20, 0, 0, 4);
    cyc(1, 1, 6'h14, 16'h0004, "R9 clear meets hit");
    rd_chk(6'h14, "R9 set wins");

    // random mix
    for (int it = 0; it < 600; it++) begin
      r = int'($urandom(seed) % 100);
      seed = seed + 32'h9E37;
      case (1'b1)
        (r < 45): cyc(1, 0, 0, 0, "R3 rnd tick");
        (r < 55): cyc(1, 1, 6'h04, 16'($urandom % 60), "R6 rnd sec");
        (r < 62): cyc($urandom % 2 == 1, 1, 6'h00,
                      16'((($urandom % 24) << 8) | ($urandom % 60)), "R6 rnd hm");
        (r < 66): cyc($urandom % 2 == 1, 1, 6'h20, 16'($urandom), "R6 rnd day");
        (r < 78): begin
          cyc(0, 1, 6'h24, 16'(m_day), "R7 rnd aday");
          cyc(0, 1, 6'h08, 16'((m_hr << 8) | m_min), "R7 rnd ahm");
          cyc(1, 1, 6'h0C, 16'((m_sec + 1 + $urandom % 3) % 60), "R7 rnd asec");
        end
        (r < 84): cyc($urandom % 2 == 1, 1, 6'h14, 16'($urandom), "R9 rnd stat");
        (r < 88): cyc($urandom % 2 == 1, 1, 6'h10, ($urandom % 4 == 0) ? 16'h0 : 16'h80, "R5 rnd ctrl");
        default:  cyc(0, 0, 0, 0, "R8 rnd idle");
      endcase
      chk_time("R3 rnd time");
      rd_chk(6'h14, "R9 rnd stat");
    end

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule